// File: doc/BRIEF.md
# Multiplexed-Bus to Asynchronous SRAM Bridge

This bridge connects a host whose 16-bit address and data share the same lines to an asynchronous SRAM that has its own address bus, data bus and active-low strobes. The host first places the low 16 address bits on the shared lines while its active-low address-valid strobe is low. The bridge keeps that value when the strobe returns high, which ends the address phase. The host then runs a read or write data phase with its active-low read and write strobes. The bridge samples the host strobes on its own clock and turns them into SRAM output-enable and write-enable pulses. It also moves data between the shared lines and the SRAM data bus.

A static mode input selects one of two layouts. In split mode, the upper half of the shared bus carries extra address bits during the data phase, and only the lower half carries data. The SRAM then sees an 8-bit data path on its low byte. In full-width mode, all shared lines carry data, and the bits above the low 16 come from dedicated high-address inputs. With the default 24-bit SRAM address, either layout reaches far more than 1 MB.

Control is a five-state machine:
- `ST_IDLE` is entered from reset. No address is held yet, so it ignores data strobes.
- Any state goes to `ST_ADDR` whenever the address-valid strobe is low.
- `ST_ADDR` goes to `ST_HOLD` on the clock where that strobe is seen high again.
- `ST_HOLD` goes to `ST_READ` when only the read strobe is low, and to `ST_WRITE` when only the write strobe is low. It stays in `ST_HOLD` if both are low.
- `ST_READ` and `ST_WRITE` return to `ST_HOLD` once their strobe is released.

Top module: `muxbus_sram_bridge`

## Requirements
- R1: After reset, sram_oe_n and sram_we_n are 1, host_bus_oe and sram_dq_oe are 0, and sram_addr is 0.
- R2: The value on host_bus_in at the last clock edge where host_adv_n was low appears on sram_addr[15:0]. It stays there until the next clock edge where host_adv_n is low.
- R3: In split mode (split_mode=1), sram_addr[23:16] equals host_bus_in[15:8] as sampled at the last clock edge where host_adv_n was high, an address was held, and host_rd_n or host_wr_n was low. It holds that value between strobes.
- R4: In full-width mode (split_mode=0), sram_addr[23:16] follows host_ahi combinationally.
- R5: With an address held, host_rd_n low and host_wr_n high at a clock edge drive sram_oe_n to 0 after that edge. The first edge where host_rd_n is high returns sram_oe_n to 1.
- R6: With an address held, host_wr_n low and host_rd_n high at a clock edge drive sram_we_n to 0 after that edge. The first edge where host_wr_n is high returns sram_we_n to 1.
- R7: After any clock edge where host_adv_n is low, sram_oe_n and sram_we_n are 1 and both enable outputs are 0, whatever the read and write strobes are doing.
- R8: While sram_oe_n is 0, host_bus_oe is 2'b01 in split mode and host_bus_out is {8'h00, sram_dq_in[7:0]}. In full-width mode host_bus_oe is 2'b11 and host_bus_out is sram_dq_in. At other times host_bus_oe is 0.
- R9: While sram_we_n is 0, sram_dq_oe is 2'b01 in split mode and sram_dq_out is {8'h00, host_bus_in[7:0]}. In full-width mode sram_dq_oe is 2'b11 and sram_dq_out is host_bus_in. At other times sram_dq_oe is 0.
- R10: Read and write strobes between reset and the first address phase have no effect: sram_oe_n and sram_we_n stay 1.
- R11: If host_rd_n and host_wr_n are both low while an address is held and no access is running, neither SRAM strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock; host strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_mode | input | 1 | Static layout select: 1 split, 0 full-width |
| host_adv_n | input | 1 | Active-low address-valid strobe; its rising edge ends the address phase |
| host_rd_n | input | 1 | Active-low host read strobe |
| host_wr_n | input | 1 | Active-low host write strobe |
| host_bus_in | input | 16 | Shared address/data lines as driven by the host |
| host_bus_out | output | 16 | Read data driven toward the shared lines |
| host_bus_oe | output | 2 | Per-half drive enable for host_bus_out ([0] low byte, [1] high byte) |
| host_ahi | input | 8 | Dedicated high address lines used in full-width mode |
| sram_addr | output | 24 | SRAM address |
| sram_dq_in | input | 16 | Data returned by the SRAM |
| sram_dq_out | output | 16 | Write data to the SRAM |
| sram_dq_oe | output | 2 | Per-half drive enable for sram_dq_out |
| sram_oe_n | output | 1 | Active-low SRAM output enable |
| sram_we_n | output | 1 | Active-low SRAM write enable |

## Verification
The bench builds the bridge with its default parameters: a 16-bit shared bus and a 24-bit SRAM address. This default places the full upper byte of the shared bus above the latched low 16 bits in split mode. Both layouts are swept over a dense, arithmetically spaced set of low addresses, upper bytes, dedicated high-address values and write data, with reads and writes interleaved. All-zero and all-ones boundary accesses are added. A small SRAM model returns a known function of the address, so every returned word can be predicted in the bench. Separate sequences cover strobes before the first address phase, strobes held during an address phase, and both strobes asserted together.

// File: rtl/muxbus_sram_pkg.sv
package muxbus_sram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_READ,
        ST_WRITE
    } bridge_state_t;

endpackage

// File: rtl/muxbus_sram_fsm.sv
module muxbus_sram_fsm
    import muxbus_sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic armed,
    output logic rd_active,
    output logic wr_active
);

    bridge_state_t state_q;
    bridge_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: address phase pre-empts everything
    always_comb begin
        state_d = state_q;
        if (!adv_n) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ADDR:  state_d = ST_HOLD;
                ST_HOLD: begin
                    if (!rd_n && wr_n) begin
                        state_d = ST_READ;
                    end else if (!wr_n && rd_n) begin
                        state_d = ST_WRITE;
                    end
                end
                ST_READ:  if (rd_n) state_d = ST_HOLD;
                ST_WRITE: if (wr_n) state_d = ST_HOLD;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        armed     = 1'b0;
        rd_active = 1'b0;
        wr_active = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ADDR:  ;
            ST_HOLD:  armed = 1'b1;
            ST_READ: begin
                armed     = 1'b1;
                rd_active = 1'b1;
            end
            ST_WRITE: begin
                armed     = 1'b1;
                wr_active = 1'b1;
            end
            default:  ;
        endcase
    end

endmodule

// File: rtl/muxbus_sram_addr.sv
module muxbus_sram_addr #(
    parameter int BUS_W   = 16,
    parameter int SRAM_AW = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       split_mode,
    input  logic                       adv_n,
    input  logic                       rd_n,
    input  logic                       wr_n,
    input  logic                       armed,
    input  logic [BUS_W-1:0]           bus_in,
    input  logic [SRAM_AW-BUS_W-1:0]   ahi,
    output logic [SRAM_AW-1:0]         addr
);

    localparam int HI_W = SRAM_AW - BUS_W;
    localparam int HALF = BUS_W / 2;

    logic [BUS_W-1:0] lo_q;
    logic [HI_W-1:0]  hi_q;
    logic             hi_load;

    // low address follows the bus while the address strobe is low,
    // so the value seen at its rising edge is what remains
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (!adv_n) begin
            lo_q <= bus_in;
        end
    end

    // upper address from the shared bus, taken during an active strobe
    assign hi_load = armed && adv_n && (!rd_n || !wr_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (hi_load) begin
            hi_q <= bus_in[HALF +: HI_W];
        end
    end

    assign addr = {(split_mode ? hi_q : ahi), lo_q};

endmodule

// File: rtl/muxbus_sram_datapath.sv
module muxbus_sram_datapath #(
    parameter int BUS_W = 16
) (
    input  logic             split_mode,
    input  logic             rd_active,
    input  logic             wr_active,
    input  logic [BUS_W-1:0] host_in,
    input  logic [BUS_W-1:0] sram_in,
    output logic [BUS_W-1:0] host_out,
    output logic [1:0]       host_oe,
    output logic [BUS_W-1:0] sram_out,
    output logic [1:0]       sram_oe
);

    localparam int HALF = BUS_W / 2;

    // lane 0 always carries data; lane 1 only in full-width mode
    for (genvar g = 0; g < 2; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign host_out[HALF-1:0] = sram_in[HALF-1:0];
            assign sram_out[HALF-1:0] = host_in[HALF-1:0];
            assign host_oe[g]         = rd_active;
            assign sram_oe[g]         = wr_active;
        end else begin : g_high
            assign host_out[BUS_W-1:HALF] = split_mode ? '0 : sram_in[BUS_W-1:HALF];
            assign sram_out[BUS_W-1:HALF] = split_mode ? '0 : host_in[BUS_W-1:HALF];
            assign host_oe[g]             = rd_active && !split_mode;
            assign sram_oe[g]             = wr_active && !split_mode;
        end
    end

endmodule

// File: rtl/muxbus_sram_bridge.sv
module muxbus_sram_bridge #(
    parameter int BUS_W   = 16,
    parameter int SRAM_AW = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     split_mode,
    input  logic                     host_adv_n,
    input  logic                     host_rd_n,
    input  logic                     host_wr_n,
    input  logic [BUS_W-1:0]         host_bus_in,
    output logic [BUS_W-1:0]         host_bus_out,
    output logic [1:0]               host_bus_oe,
    input  logic [SRAM_AW-BUS_W-1:0] host_ahi,
    output logic [SRAM_AW-1:0]       sram_addr,
    input  logic [BUS_W-1:0]         sram_dq_in,
    output logic [BUS_W-1:0]         sram_dq_out,
    output logic [1:0]               sram_dq_oe,
    output logic                     sram_oe_n,
    output logic                     sram_we_n
);

    logic armed;
    logic rd_active;
    logic wr_active;

    muxbus_sram_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_n     (host_adv_n),
        .rd_n      (host_rd_n),
        .wr_n      (host_wr_n),
        .armed     (armed),
        .rd_active (rd_active),
        .wr_active (wr_active)
    );

    muxbus_sram_addr #(
        .BUS_W   (BUS_W),
        .SRAM_AW (SRAM_AW)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .split_mode (split_mode),
        .adv_n      (host_adv_n),
        .rd_n       (host_rd_n),
        .wr_n       (host_wr_n),
        .armed      (armed),
        .bus_in     (host_bus_in),
        .ahi        (host_ahi),
        .addr       (sram_addr)
    );

    muxbus_sram_datapath #(
        .BUS_W (BUS_W)
    ) u_dp (
        .split_mode (split_mode),
        .rd_active  (rd_active),
        .wr_active  (wr_active),
        .host_in    (host_bus_in),
        .sram_in    (sram_dq_in),
        .host_out   (host_bus_out),
        .host_oe    (host_bus_oe),
        .sram_out   (sram_dq_out),
        .sram_oe    (sram_dq_oe)
    );

    assign sram_oe_n = !rd_active;
    assign sram_we_n = !wr_active;

endmodule

// File: rtl/muxbus_sram_bridge_checker.sv
module muxbus_sram_bridge_checker #(
    parameter int BUS_W   = 16,
    parameter int SRAM_AW = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_adv_n,
    input logic               host_rd_n,
    input logic               host_wr_n,
    input logic [1:0]         host_bus_oe,
    input logic [SRAM_AW-1:0] sram_addr,
    input logic [1:0]         sram_dq_oe,
    input logic               sram_oe_n,
    input logic               sram_we_n
);

    p_addr_phase_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_adv_n |=> (sram_oe_n && sram_we_n && host_bus_oe == 2'b00 && sram_dq_oe == 2'b00));

    p_low_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_adv_n |=> $stable(sram_addr[BUS_W-1:0]));

    p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_oe_n && host_rd_n && host_adv_n) |=> sram_oe_n);

    p_write_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && host_wr_n && host_adv_n) |=> sram_we_n);

    p_drive_needs_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_bus_oe != 2'b00) |-> $past(!host_rd_n));

    p_single_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n));

endmodule

bind muxbus_sram_bridge muxbus_sram_bridge_checker #(
    .BUS_W   (BUS_W),
    .SRAM_AW (SRAM_AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_adv_n  (host_adv_n),
    .host_rd_n   (host_rd_n),
    .host_wr_n   (host_wr_n),
    .host_bus_oe (host_bus_oe),
    .sram_addr   (sram_addr),
    .sram_dq_oe  (sram_dq_oe),
    .sram_oe_n   (sram_oe_n),
    .sram_we_n   (sram_we_n)
);

// File: tb/muxbus_sram_bridge_bench.sv
module muxbus_sram_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        split_mode = 1'b0;
    logic        host_adv_n = 1'b1;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic [15:0] host_bus_in = '0;
    logic [15:0] host_bus_out;
    logic [1:0]  host_bus_oe;
    logic [7:0]  host_ahi = '0;
    logic [23:0] sram_addr;
    logic [15:0] sram_dq_in;
    logic [15:0] sram_dq_out;
    logic [1:0]  sram_dq_oe;
    logic        sram_oe_n;
    logic        sram_we_n;

    int vec_cnt = 0;
    int bad_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // SRAM model: word is a fixed function of the address
    function automatic logic [15:0] mem_word(input logic [23:0] a);
        return a[15:0] ^ {a[23:16], 8'h3C};
    endfunction

    assign sram_dq_in = mem_word(sram_addr);

    muxbus_sram_bridge u_muxbus_sram_bridge (
        .clk          (clk),
        .rst_n        (rst_n),
        .split_mode   (split_mode),
        .host_adv_n   (host_adv_n),
        .host_rd_n    (host_rd_n),
        .host_wr_n    (host_wr_n),
        .host_bus_in  (host_bus_in),
        .host_bus_out (host_bus_out),
        .host_bus_oe  (host_bus_oe),
        .host_ahi     (host_ahi),
        .sram_addr    (sram_addr),
        .sram_dq_in   (sram_dq_in),
        .sram_dq_out  (sram_dq_out),
        .sram_dq_oe   (sram_dq_oe),
        .sram_oe_n    (sram_oe_n),
        .sram_we_n    (sram_we_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            bad_cnt++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic quiet(input string req);
        chk(req, {30'd0, sram_oe_n, sram_we_n}, 32'd3);
        chk(req, {28'd0, host_bus_oe, sram_dq_oe}, 32'd0);
    endtask

    task automatic latch_addr(input logic [15:0] lo);
        @(negedge clk);
        host_adv_n  = 1'b0;
        host_bus_in = lo;
        @(negedge clk);
        quiet("R7");
        chk("R2", {16'd0, sram_addr[15:0]}, {16'd0, lo});
        host_adv_n  = 1'b1;
        host_bus_in = ~lo;
        @(negedge clk);
        chk("R2", {16'd0, sram_addr[15:0]}, {16'd0, lo});
    endtask

    task automatic access(input bit wr, input logic [15:0] lo, input logic [7:0] upper,
                          input logic [7:0] ahi, input logic [15:0] wd);
        logic [23:0] ea;
        logic [15:0] rw;
        host_ahi = ahi;
        latch_addr(lo);
        host_bus_in = split_mode ? {upper, wd[7:0]} : wd;
        if (wr) host_wr_n = 1'b0;
        else    host_rd_n = 1'b0;
        @(negedge clk);
        ea = {(split_mode ? upper : ahi), lo};
        chk(split_mode ? "R3" : "R4", {8'd0, sram_addr}, {8'd0, ea});
        if (wr) begin
            chk("R6", {31'd0, sram_we_n}, 32'd0);
            chk("R6", {31'd0, sram_oe_n}, 32'd1);
            chk("R9", {30'd0, sram_dq_oe}, split_mode ? 32'd1 : 32'd3);
            chk("R9", {16'd0, sram_dq_out}, split_mode ? {24'd0, wd[7:0]} : {16'd0, wd});
            chk("R8", {30'd0, host_bus_oe}, 32'd0);
        end else begin
            rw = mem_word(ea);
            chk("R5", {31'd0, sram_oe_n}, 32'd0);
            chk("R5", {31'd0, sram_we_n}, 32'd1);
            chk("R8", {30'd0, host_bus_oe}, split_mode ? 32'd1 : 32'd3);
            chk("R8", {16'd0, host_bus_out}, split_mode ? {24'd0, rw[7:0]} : {16'd0, rw});
            chk("R9", {30'd0, sram_dq_oe}, 32'd0);
        end
        if (!split_mode) begin
            host_ahi = ~ahi;
            #1;
            chk("R4", {24'd0, sram_addr[23:16]}, {24'd0, ~ahi});
            host_ahi = ahi;
        end
        host_rd_n = 1'b1;
        host_wr_n = 1'b1;
        host_bus_in = 16'h5AA5;
        @(negedge clk);
        chk(wr ? "R6" : "R5", {30'd0, sram_oe_n, sram_we_n}, 32'd3);
        chk("R2", {16'd0, sram_addr[15:0]}, {16'd0, lo});
        if (split_mode) chk("R3", {24'd0, sram_addr[23:16]}, {24'd0, upper});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad_cnt++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {8'd0, sram_addr}, 32'd0);
        quiet("R1");
        rst_n = 1'b1;

        // R10: strobes before any address phase
        @(negedge clk);
        host_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        quiet("R10");
        host_rd_n = 1'b1;
        host_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        quiet("R10");
        host_wr_n = 1'b1;

        for (int m = 0; m < 2; m++) begin
            split_mode = m[0];
            // R7: read strobe held through an address phase
            @(negedge clk);
            host_rd_n   = 1'b0;
            host_adv_n  = 1'b0;
            host_bus_in = 16'h1234;
            @(negedge clk);
            quiet("R7");
            @(negedge clk);
            quiet("R7");
            host_adv_n = 1'b1;
            host_rd_n  = 1'b1;
            @(negedge clk);

            // R11: both strobes together
            latch_addr(16'hBEEF);
            host_rd_n = 1'b0;
            host_wr_n = 1'b0;
            repeat (2) @(negedge clk);
            quiet("R11");
            host_rd_n = 1'b1;
            host_wr_n = 1'b1;
            @(negedge clk);

            // boundary accesses
            access(1'b0, 16'h0000, 8'h00, 8'h00, 16'h0000);
            access(1'b1, 16'hFFFF, 8'hFF, 8'hFF, 16'hFFFF);
            access(1'b0, 16'hFFFF, 8'hFF, 8'hFF, 16'h0000);
            access(1'b1, 16'h0000, 8'h00, 8'h00, 16'h8001);

            for (int i = 0; i < 48; i++) begin
                access(i[0], 16'(i * 16'h2B9D + 16'h0101), 8'(i * 29 + 7),
                       8'(i * 53 + 1), 16'((i * 16'h03A7) ^ 16'hC35A));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

endmodule